// File: doc/BRIEF.md
# Stretchable External Memory Cycle Sequencer

This block produces the timing of single accesses to external data memory on a small 8-bit microcontroller bus. A request brings a direction flag, a 16-bit address, write data and a 3-bit stretch setting. The block then drives an address-valid window and either a read strobe or a write strobe. Both strobes are active high. The window length follows the stretch setting, so slow memories can be reached without extra logic in the core.

Reads and writes stretch by different rules. On a read, the strobe covers the whole address window. On a write, the window is one cycle longer, and the write strobe sits at the tail of the window, so the address is settled before the strobe rises. Completion is marked by a single-cycle done pulse. The read byte stays on its own output until the next read finishes.

Top module: `xmem_cycle_seq`

## Requirements
- R1: Out of reset and whenever busy_o is low, addr_vld_o, rd_stb_o, wr_stb_o and done_o are all low, and rdata_o is 0 after reset.
- R2: A read accepted at a clock edge (req_i high while idle, wr_i = 0) raises addr_vld_o in the next cycle and holds it for exactly stretch+1 cycles.
- R3: During a read, rd_stb_o is high in exactly the cycles in which addr_vld_o is high, and wr_stb_o stays low.
- R4: A write (wr_i = 1) holds addr_vld_o for exactly stretch+2 cycles, beginning in the cycle after acceptance.
- R5: During a write, wr_stb_o is high for 1 cycle when stretch is 0 or 1, and for stretch cycles when stretch is 2 to 7. It occupies the final cycles of the address window and is never high in the first cycle of the window.
- R6: While addr_vld_o is high, bus_addr_o equals the accepted address. While wr_stb_o is high, bus_wdata_o equals the accepted write data.
- R7: rdata_o takes the value of bus_rdata_i from the last strobe cycle of a read. It presents that value from the done cycle onward and changes only when a later read completes.
- R8: The stretch setting and the direction are taken at acceptance. Changing stretch_i or wr_i later has no effect on the access in progress.
- R9: done_o is high for exactly one cycle, the cycle right after the address window. busy_o is high from the first window cycle through the done cycle. A request present in the done cycle is not taken, and a request present in the next cycle is taken.
- R10: req_i is ignored while busy_o is high: a request raised during an access alters neither the ongoing access nor its address and data.
- R11: rd_stb_o and wr_stb_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| wr_i | input | 1 | Direction of the request: 1 write, 0 read |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Request write data |
| stretch_i | input | 3 | Stretch setting 0 to 7 |
| bus_addr_o | output | 16 | Address driven to memory |
| bus_wdata_o | output | 8 | Write data driven to memory |
| bus_rdata_i | input | 8 | Data returned by memory |
| addr_vld_o | output | 1 | Address window active |
| rd_stb_o | output | 1 | Read strobe, active high |
| wr_stb_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | Access in progress, including the done cycle |
| done_o | output | 1 | Single-cycle completion pulse |
| rdata_o | output | 8 | Data from the most recent completed read |

## Verification
A wrong cycle count or a stretch value picked up late shows up as a window or strobe edge that is off by one cycle. A per-cycle reference comparison catches this in the very cycle the edge is expected. A direction flag that is latched wrongly shows up at once as the wrong strobe in the first window cycle. A corrupted capture of address, data or read value is seen during that window on the bus. It also appears later, at the done cycle of a read that returns the byte written earlier, because the bench memory stores whatever the strobe wrote.

// File: rtl/xmem_pkg.sv
// Package: shared state type and the stretch-to-length rules of the
// external memory cycle sequencer. Assumes stretch values 0..7.
package xmem_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_DONE   = 2'd2
    } seq_state_t;

    // Address window length in cycles for a given stretch and direction.
    function automatic int window_cycles(input int stretch, input logic is_write);
        return is_write ? stretch + 2 : stretch + 1;
    endfunction

    // Write strobe length in cycles for a given stretch.
    function automatic int wstrobe_cycles(input int stretch);
        return (stretch < 2) ? 1 : stretch;
    endfunction

endpackage

// File: rtl/xmem_seq_ctrl.sv
// Module: top-level sequencing state machine. Accepts a request only when
// idle, holds the access state until the phase timer reports the last
// window cycle, then emits one done cycle before returning to idle.
// Assumes phase_last_i is meaningful only while access_o is high.
module xmem_seq_ctrl
    import xmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic phase_last_i,
    output logic accept_o,
    output logic access_o,
    output logic done_o,
    output logic busy_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Request is taken only from the idle state.
    assign accept_o = (state_q == SEQ_IDLE) && req_i;
    assign access_o = (state_q == SEQ_ACCESS);
    assign done_o   = (state_q == SEQ_DONE);
    assign busy_o   = (state_q != SEQ_IDLE);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (req_i) state_d = SEQ_ACCESS;
            SEQ_ACCESS: if (phase_last_i) state_d = SEQ_DONE;
            SEQ_DONE:   state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Done lasts a single cycle.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // After done the sequencer is idle again.
    p_done_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // A request seen during an access never restarts it.
    p_busy_ignores_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (access_o && !phase_last_i) |=> access_o);

endmodule

// File: rtl/xmem_phase_timer.sv
// Module: counts the address window of one access. At acceptance it latches
// direction and stretch, loads the window length minus one, and counts down
// while the access runs. It reports the last window cycle and whether the
// current cycle lies inside the trailing write strobe slot.
// Assumes load_i and run_i are never high together.
module xmem_phase_timer
    import xmem_pkg::*;
#(
    parameter int STRETCH_W = 3
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 run_i,
    input  logic                 wr_i,
    input  logic [STRETCH_W-1:0] stretch_i,
    output logic                 last_o,
    output logic                 wwin_o,
    output logic                 wr_q_o
);

    localparam int MAX_STRETCH = (1 << STRETCH_W) - 1;
    localparam int MAX_LEN     = MAX_STRETCH + 2;
    localparam int CNT_W       = $clog2(MAX_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wlen_q;
    logic             wr_q;
    logic [CNT_W-1:0] load_cnt;
    logic [CNT_W-1:0] load_wlen;

    // Length values computed from the request at acceptance.
    always_comb begin
        load_cnt  = CNT_W'(window_cycles(int'(stretch_i), wr_i) - 1);
        load_wlen = CNT_W'(wstrobe_cycles(int'(stretch_i)));
    end

    // Latch direction and strobe length, then count the window down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wlen_q <= '0;
            wr_q   <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= load_cnt;
            wlen_q <= load_wlen;
            wr_q   <= wr_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
    assign wwin_o = (cnt_q < wlen_q);
    assign wr_q_o = wr_q;

    // Window shrinks by one every running cycle until the end.
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !last_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // Write strobe slot reaches the last window cycle.
    p_wslot_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wr_q && last_o) |-> wwin_o);

    // Write strobe slot never covers the first window cycle.
    p_wslot_not_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_i) && wr_q) |-> !wwin_o);

    // Direction does not change while the access runs.
    p_dir_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> $stable(wr_q));

endmodule

// File: rtl/xmem_bus_regs.sv
// Module: holds address and write data for the duration of an access and
// keeps the byte returned by the most recent read. Assumes cap_i is high
// only in the last strobe cycle of a read.
module xmem_bus_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Capture request address and data when the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Keep the byte from the final read strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (cap_i) rdata_q <= rdata_i;
    end

    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;

    // Read byte only changes on a capture.
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(rdata_q));

    // Address is not reloaded together with a capture.
    p_no_load_on_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |-> !load_i);

endmodule

// File: rtl/xmem_cycle_seq.sv
// Module: external data memory cycle sequencer. Combines the state machine,
// the phase timer and the bus registers, and decodes the address window and
// the read and write strobes. Assumes the memory answers combinationally
// within a strobe cycle.
module xmem_cycle_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int STRETCH_W = 3
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [STRETCH_W-1:0] stretch_i,
    output logic [ADDR_W-1:0]    bus_addr_o,
    output logic [DATA_W-1:0]    bus_wdata_o,
    input  logic [DATA_W-1:0]    bus_rdata_i,
    output logic                 addr_vld_o,
    output logic                 rd_stb_o,
    output logic                 wr_stb_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DATA_W-1:0]    rdata_o
);

    logic accept;
    logic access;
    logic last;
    logic wwin;
    logic wr_q;
    logic cap;

    xmem_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .phase_last_i (last),
        .accept_o     (accept),
        .access_o     (access),
        .done_o       (done_o),
        .busy_o       (busy_o)
    );

    xmem_phase_timer #(.STRETCH_W(STRETCH_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .run_i     (access),
        .wr_i      (wr_i),
        .stretch_i (stretch_i),
        .last_o    (last),
        .wwin_o    (wwin),
        .wr_q_o    (wr_q)
    );

    // Strobe decode: read covers the window, write only its trailing slot.
    always_comb begin
        addr_vld_o = access;
        rd_stb_o   = access && !wr_q;
        wr_stb_o   = access && wr_q && wwin;
        cap        = access && !wr_q && last;
    end

    xmem_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cap_i   (cap),
        .rdata_i (bus_rdata_i),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o),
        .rdata_o (rdata_o)
    );

    // Strobes are mutually exclusive.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_o && wr_stb_o));

    // Read strobe only inside the address window.
    p_rd_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> addr_vld_o);

    // Write strobe only inside the address window.
    p_wr_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> addr_vld_o);

    // Address is steady across the window.
    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && $past(addr_vld_o)) |-> $stable(bus_addr_o));

    // Idle bus is quiet.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!addr_vld_o && !rd_stb_o && !wr_stb_o && !done_o));

    // Done follows the end of the window.
    p_done_after_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_vld_o) |-> done_o);

endmodule

// File: tb/xmem_cycle_seq_test.sv
`timescale 1ns/1ps
// Bench: drives reads and writes at every stretch, compares the ports on each
// cycle against a behavioural reference and a byte-wide memory model.
module xmem_cycle_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [2:0]  stretch_i = '0;
    logic [15:0] bus_addr_o;
    logic [7:0]  bus_wdata_o;
    logic [7:0]  bus_rdata_i;
    logic        addr_vld_o, rd_stb_o, wr_stb_o, busy_o, done_o;
    logic [7:0]  rdata_o;

    always #5 clk = ~clk;

    xmem_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .stretch_i(stretch_i),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i), .addr_vld_o(addr_vld_o),
        .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .busy_o(busy_o),
        .done_o(done_o), .rdata_o(rdata_o)
    );

    // Memory model: answers during the read strobe, stores on write strobe.
    logic [7:0] mem [0:255];
    assign bus_rdata_i = rd_stb_o ? mem[bus_addr_o[7:0]] : 8'h00;
    always @(posedge clk) if (wr_stb_o) mem[bus_addr_o[7:0]] <= bus_wdata_o;

    // Reference state.
    int         m_st = 0;
    int         m_k, m_len, m_wlen;
    logic       m_wr;
    logic [15:0] m_addr;
    logic [7:0]  m_wd;
    logic [7:0]  m_rd = 8'h00;
    logic [7:0]  shadow [0:255];
    int         nvec = 0, nmis = 0, wcount = 0;
    bit         finished = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
    end

    // Reference: 0 idle, 1 window, 2 done.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rd = 8'h00;
        end else begin
            case (m_st)
                0: if (req_i) begin
                    m_st = 1; m_k = 0; m_wr = wr_i; m_addr = addr_i; m_wd = wdata_i;
                    m_len  = wr_i ? int'(stretch_i) + 2 : int'(stretch_i) + 1;
                    m_wlen = (stretch_i < 3'd2) ? 1 : int'(stretch_i);
                end
                1: if (m_k == m_len - 1) begin
                    m_st = 2;
                    if (m_wr) shadow[m_addr[7:0]] = m_wd;
                    else      m_rd = shadow[m_addr[7:0]];
                end else m_k = m_k + 1;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nmis++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic ev, ewr;
            ev  = (m_st == 1);
            ewr = ev && m_wr && (m_k >= m_len - m_wlen);
            chk(ev && !m_wr ? "R2" : (ev ? "R4" : "R1"), "addr_vld", int'(addr_vld_o), int'(ev));
            chk("R3", "rd_stb", int'(rd_stb_o), int'(ev && !m_wr));
            chk("R5", "wr_stb", int'(wr_stb_o), int'(ewr));
            chk("R9", "done", int'(done_o), int'(m_st == 2));
            chk("R9", "busy", int'(busy_o), int'(m_st != 0));
            chk("R7", "rdata", int'(rdata_o), int'(m_rd));
            chk("R11", "strobe overlap", int'(rd_stb_o && wr_stb_o), 0);
            if (ev)  chk("R6", "bus_addr", int'(bus_addr_o), int'(m_addr));
            if (ewr) chk("R6", "bus_wdata", int'(bus_wdata_o), int'(m_wd));
            if (wr_stb_o) wcount++;
            if (m_st == 2 && m_wr) begin
                chk("R5", "write strobe length", wcount, m_wlen);
                wcount = 0;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (m_st != 0);
    endtask

    // One access; after acceptance the stretch and direction inputs are
    // scrambled (R8) and a stray request is raised mid-access (R10).
    task automatic xfer(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input logic [2:0] s, input bit disturb);
        @(negedge clk);
        req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d; stretch_i = s;
        @(negedge clk);
        req_i = 1'b0;
        if (disturb) begin
            stretch_i = ~s; wr_i = ~w; addr_i = ~a; wdata_i = ~d;
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        chk("R1", "reset addr_vld", int'(addr_vld_o), 0);
        chk("R1", "reset strobes", int'(rd_stb_o | wr_stb_o), 0);
        chk("R1", "reset busy", int'(busy_o), 0);
        chk("R1", "reset rdata", int'(rdata_o), 0);
        rst_n = 1'b1;
        // R2..R7 across every stretch value.
        for (int s = 0; s < 8; s++) begin
            xfer(1'b1, 16'h1200 + 16'(s), 8'hA0 + 8'(s), 3'(s), 0);
            xfer(1'b0, 16'h1200 + 16'(s), 8'h00, 3'(s), 0);
            xfer(1'b0, 16'hFF00 + 16'(s * 9), 8'h00, 3'(7 - s), 0);
        end
        // R8 and R10: inputs disturbed during the access.
        for (int s = 0; s < 8; s++) begin
            xfer(1'b1, 16'h0040 + 16'(s), 8'h3C ^ 8'(s), 3'(s), 1);
            xfer(1'b0, 16'h0040 + 16'(s), 8'h00, 3'(s), 1);
        end
        // R9: request held high, re-accepted right after each done.
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b0; addr_i = 16'h0077; stretch_i = 3'd2;
        repeat (20) @(negedge clk);
        wr_i = 1'b1; wdata_i = 8'hE1; stretch_i = 3'd0;
        repeat (20) @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        xfer(1'b0, 16'h0077, 8'h00, 3'd1, 0);
        chk("R7", "read after write", int'(rdata_o), 8'hE1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    // Watchdog.
    initial begin
        #(150000 * 10);
        if (!finished) begin
            nmis++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

endmodule